// File: doc/BRIEF.md
# SONET Transport Overhead Inserter with Test Injection

This block sits on the transmit side of a byte-wide STS-1 frame stream. A frame is 9 rows of 90 bytes, and the first 3 columns of each row carry transport overhead. The upstream logic supplies every byte of the frame. It marks the first byte with a start flag, and it may leave idle cycles between bytes.

For each frame the block does four things:
- It writes the two framing bytes.
- It writes a bit-interleaved parity byte, computed over the previous output frame.
- It optionally forces a fault code into the protection-signalling byte.
- It scrambles everything except the framing bytes with a frame-synchronous scrambler.

The result leaves one cycle later, together with a start-of-frame pulse.

Four control inputs support link testing:
- One inverts the framing bytes.
- One inverts the parity byte.
- One forces the fault code.
- One passes all overhead columns through from the input, untouched and unscrambled.

The controls are sampled once, on the start byte of each frame.

Top module: `oh_inserter`

## Requirements
- R1: Every byte accepted with `in_valid` high appears on `out_data` with `out_valid` high exactly one cycle later. `out_sof` is high on that cycle exactly when the input byte carried `in_sof`. A byte with `in_sof` is frame position row 0, column 0.
- R2: Unless transparent mode is active, row 0 column 0 is sent as 8'hF6 and row 0 column 1 as 8'h28. Neither is scrambled.
- R3: With `ctl_frame_inv` sampled high, those two bytes are sent as 8'h09 and 8'hD7 (bitwise inverses).
- R4: Row 1 column 0 carries, before scrambling, the XOR of all output bytes of the previous frame. This value is 8'h00 for the first frame after reset. With `ctl_parity_inv` sampled high, the byte is inverted before scrambling.
- R5: Row 4 column 2 carries the input byte before scrambling. With `ctl_fault` sampled high, it carries 8'h06 instead.
- R6: With `ctl_transparent` sampled high, every byte in columns 0 to 2 is output exactly as input and unscrambled. This overrides R2 to R5.
- R7: The following bytes are XORed with a keystream from the generator 1 + x^6 + x^7:
  - all bytes outside row 0 columns 0 and 1;
  - not the overhead bytes that R6 passes through.

  The generator state is set to all ones at row 0 column 2, and bits are taken MSB first, so the first keystream byte is 8'hFE. Bytes that follow in frame order take the following keystream bytes.
- R8: The controls are sampled only on the `in_sof` byte. Changes on other cycles have no effect until the next frame.
- R9: While `rst` is high and on the cycle after, `out_valid` and `out_sof` are low.
- R10: A cycle with `in_valid` low produces no output byte and does not advance the frame position or the keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is row 0 column 0 |
| in_data | input | 8 | Input frame byte |
| ctl_frame_inv | input | 1 | Invert the framing bytes |
| ctl_parity_inv | input | 1 | Invert the parity byte |
| ctl_fault | input | 1 | Force fault code into the signalling byte |
| ctl_transparent | input | 1 | Pass overhead columns through unchanged |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is the first framing byte |
| out_data | output | 8 | Output frame byte |

## Verification
The assertions assume the following about the inputs:
- The control inputs hold their value through the cycle in which the start byte is accepted.
- `in_sof` is only raised together with `in_valid`.
- No input is ever X after reset.

The stimulus keeps to this by driving every input on the falling edge, and by raising the start flag only on valid bytes. The stimulus also scrambles the controls after the start byte of one frame. This tests that mid-frame changes are ignored without ever breaking the sampling assumption. Every frame is delivered complete, so the parity carried into each next frame covers a whole frame.

// File: rtl/oh_pkg.sv
package oh_pkg;
    localparam logic [7:0] A1_BYTE  = 8'hF6;
    localparam logic [7:0] A2_BYTE  = 8'h28;
    localparam logic [7:0] FAULT_K2 = 8'h06;
    localparam int SCR_W            = 7;
    localparam int FRAMING_BYTES    = 2;
    localparam logic [SCR_W-1:0] SCR_SEED = '1;

    typedef struct packed {
        logic frame_inv;
        logic parity_inv;
        logic fault;
        logic transparent;
    } oh_ctrl_t;

    typedef enum logic [2:0] {
        SLOT_A1,
        SLOT_A2,
        SLOT_B1,
        SLOT_K2,
        SLOT_OH,
        SLOT_PAYLOAD
    } slot_e;

    // Keystream byte produced from a generator state, MSB first.
    function automatic logic [7:0] scr_key(input logic [SCR_W-1:0] s);
        logic [SCR_W-1:0] t;
        logic [7:0] k;
        t = s;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = t[SCR_W-1];
            t = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
        end
        return k;
    endfunction

    // Generator state after eight bit steps.
    function automatic logic [SCR_W-1:0] scr_adv(input logic [SCR_W-1:0] s);
        logic [SCR_W-1:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
        end
        return t;
    endfunction
endpackage

// File: rtl/oh_position.sv
module oh_position #(
    parameter int ROWS = 9,
    parameter int COLS = 90,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;

    always_comb begin
        if (in_sof) begin
            cur_row = '0;
            cur_col = '0;
        end else if (col_q == LAST_COL) begin
            cur_col = '0;
            cur_row = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
        end else begin
            cur_col = col_q + 1'b1;
            cur_row = row_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= LAST_ROW;
            col_q <= LAST_COL;
        end else if (in_valid) begin
            row_q <= cur_row;
            col_q <= cur_col;
        end
    end
endmodule

// File: rtl/oh_scrambler.sv
module oh_scrambler
    import oh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       restart,
    output logic [7:0] key
);
    logic [SCR_W-1:0] state_q;
    logic [SCR_W-1:0] start;

    assign start = restart ? SCR_SEED : state_q;
    assign key   = scr_key(start);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCR_SEED;
        end else if (adv) begin
            state_q <= scr_adv(start);
        end
    end
endmodule

// File: rtl/oh_parity.sv
module oh_parity (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       frame_start,
    input  logic [7:0] byte_in,
    output logic [7:0] prev_par
);
    logic [7:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            prev_par <= '0;
        end else if (en) begin
            if (frame_start) begin
                prev_par <= acc_q;
                acc_q    <= byte_in;
            end else begin
                acc_q <= acc_q ^ byte_in;
            end
        end
    end
endmodule

// File: rtl/oh_inserter.sv
module oh_inserter
    import oh_pkg::*;
#(
    parameter int ROWS    = 9,
    parameter int COLS    = 90,
    parameter int OH_COLS = 3,
    parameter int K2_ROW  = 4,
    parameter int K2_COL  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_data,
    input  logic       ctl_frame_inv,
    input  logic       ctl_parity_inv,
    input  logic       ctl_fault,
    input  logic       ctl_transparent,
    output logic       out_valid,
    output logic       out_sof,
    output logic [7:0] out_data
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam logic [RW-1:0] K2_R  = RW'(K2_ROW);
    localparam logic [CW-1:0] K2_C  = CW'(K2_COL);
    localparam logic [CW-1:0] OH_C  = CW'(OH_COLS);
    localparam logic [CW-1:0] SCR_C = CW'(FRAMING_BYTES);

    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          start;
    oh_ctrl_t      ctrl_in, ctrl_q, ctrl;
    slot_e         slot;
    logic [7:0]    key, par, raw, next_byte;
    logic          scramble;

    assign start   = in_valid & in_sof;
    assign ctrl_in = '{frame_inv: ctl_frame_inv, parity_inv: ctl_parity_inv,
                       fault: ctl_fault, transparent: ctl_transparent};
    assign ctrl    = start ? ctrl_in : ctrl_q;

    oh_position #(.ROWS(ROWS), .COLS(COLS)) u_pos (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .cur_row(cur_row), .cur_col(cur_col)
    );

    oh_scrambler u_scr (
        .clk(clk), .rst(rst), .adv(in_valid),
        .restart(cur_row == '0 && cur_col == SCR_C),
        .key(key)
    );

    oh_parity u_par (
        .clk(clk), .rst(rst), .en(in_valid), .frame_start(start),
        .byte_in(next_byte), .prev_par(par)
    );

    always_comb begin
        if (cur_row == '0 && cur_col == '0)             slot = SLOT_A1;
        else if (cur_row == '0 && cur_col == CW'(1))    slot = SLOT_A2;
        else if (cur_row == RW'(1) && cur_col == '0)    slot = SLOT_B1;
        else if (cur_row == K2_R && cur_col == K2_C)    slot = SLOT_K2;
        else if (cur_col < OH_C)                        slot = SLOT_OH;
        else                                            slot = SLOT_PAYLOAD;
    end

    always_comb begin
        raw      = in_data;
        scramble = 1'b1;
        if (ctrl.transparent && slot != SLOT_PAYLOAD) begin
            scramble = 1'b0;
        end else begin
            unique case (slot)
                SLOT_A1: begin
                    raw      = A1_BYTE ^ {8{ctrl.frame_inv}};
                    scramble = 1'b0;
                end
                SLOT_A2: begin
                    raw      = A2_BYTE ^ {8{ctrl.frame_inv}};
                    scramble = 1'b0;
                end
                SLOT_B1: raw = par ^ {8{ctrl.parity_inv}};
                SLOT_K2: raw = ctrl.fault ? FAULT_K2 : in_data;
                default: raw = in_data;
            endcase
        end
        next_byte = scramble ? (raw ^ key) : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            if (start) ctrl_q <= ctrl_in;
            out_valid <= in_valid;
            out_sof   <= start;
            if (in_valid) out_data <= next_byte;
        end
    end
endmodule

// File: rtl/oh_inserter_chk.sv
module oh_inserter_chk
    import oh_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sof,
    input logic [7:0] in_data,
    input logic       ctl_frame_inv,
    input logic       ctl_parity_inv,
    input logic       ctl_fault,
    input logic       ctl_transparent,
    input logic       out_valid,
    input logic       out_sof,
    input logic [7:0] out_data
);
    assert_sof_follows_R1: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_sof) |-> (out_sof && out_valid));

    assert_sof_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    assert_framing_a1_R2: assert property (@(posedge clk) disable iff (rst)
        (out_sof && !$past(ctl_transparent) && !$past(ctl_frame_inv))
            |-> out_data == A1_BYTE);

    assert_framing_a1_inv_R3: assert property (@(posedge clk) disable iff (rst)
        (out_sof && !$past(ctl_transparent) && $past(ctl_frame_inv))
            |-> out_data == ~A1_BYTE);

    assert_transparent_a1_R6: assert property (@(posedge clk) disable iff (rst)
        (out_sof && $past(ctl_transparent)) |-> out_data == $past(in_data));

    assert_idle_no_output_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !out_valid);
endmodule

bind oh_inserter oh_inserter_chk u_chk (.*);

// File: tb/sim_oh_inserter.sv
module sim_oh_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 9;
    localparam int COLS = 90;
    localparam int FRAME = ROWS * COLS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       ctl_frame_inv = 1'b0;
    logic       ctl_parity_inv = 1'b0;
    logic       ctl_fault = 1'b0;
    logic       ctl_transparent = 1'b0;
    logic       out_valid, out_sof;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] data;
        bit         sof;
        bit         is_b1;
        bit         inv;
        logic [7:0] ks;
        int         req;
    } exp_t;
    exp_t q[$];

    logic [7:0] ks_tab [FRAME];
    bit         ks_bits [FRAME*8];

    oh_inserter #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .ctl_frame_inv(ctl_frame_inv), .ctl_parity_inv(ctl_parity_inv),
        .ctl_fault(ctl_fault), .ctl_transparent(ctl_transparent),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Keystream per R7: b[n+7] = b[n] ^ b[n+1], seeded with seven ones, MSB first.
    initial begin
        for (int n = 0; n < FRAME*8; n++) ks_bits[n] = (n < 7) ? 1'b1 : (ks_bits[n-7] ^ ks_bits[n-6]);
        for (int b = 0; b < FRAME; b++)
            for (int i = 0; i < 8; i++) ks_tab[b][7-i] = ks_bits[b*8+i];
    end

    task automatic check(input bit ok, input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send_frame(input bit fi, input bit pi, input bit fa, input bit tr,
                              input bit midflip, input bit gaps);
        for (int idx = 0; idx < FRAME; idx++) begin
            int r, c;
            exp_t e;
            logic [7:0] d, k;
            r = idx / COLS;
            c = idx % COLS;
            @(negedge clk);
            if (gaps && (idx % 97 == 50)) begin
                in_valid = 1'b0;
                in_sof = 1'b0;
                @(negedge clk);
                check(out_valid == 1'b0, 10, {7'd0, out_valid}, 8'h00); // R10
            end
            d = 8'($urandom);
            in_valid = 1'b1;
            in_sof = (idx == 0);
            in_data = d;
            if (idx == 0) begin
                ctl_frame_inv = fi; ctl_parity_inv = pi; ctl_fault = fa; ctl_transparent = tr;
            end else if (midflip) begin
                ctl_frame_inv = ~fi; ctl_parity_inv = ~pi; ctl_fault = ~fa; ctl_transparent = ~tr; // R8
            end
            k = (idx >= 2) ? ks_tab[idx-2] : 8'h00;
            e.sof = (idx == 0);
            e.is_b1 = 0;
            e.inv = 0;
            e.ks = k;
            if (tr && c < 3) begin
                e.data = d; e.req = 6;                          // R6
            end else if (r == 0 && c == 0) begin
                e.data = fi ? 8'h09 : 8'hF6; e.req = fi ? 3 : 2; // R2 / R3
            end else if (r == 0 && c == 1) begin
                e.data = fi ? 8'hD7 : 8'h28; e.req = fi ? 3 : 2; // R2 / R3
            end else if (r == 1 && c == 0) begin
                e.is_b1 = 1; e.inv = pi; e.data = 8'h00; e.req = 4; // R4
            end else if (r == 4 && c == 2) begin
                e.data = (fa ? 8'h06 : d) ^ k; e.req = 5;       // R5
            end else begin
                e.data = d ^ k; e.req = midflip ? 8 : 7;        // R7 / R8
            end
            q.push_back(e);
        end
    endtask

    // Monitor: compares outputs against the queue; parity over actual previous frame (R4).
    initial begin
        logic [7:0] run_par, prev_par, expb;
        exp_t e;
        run_par = 8'h00;
        prev_par = 8'h00;
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (out_sof) begin
                    prev_par = run_par;
                    run_par = out_data;
                end else begin
                    run_par ^= out_data;
                end
                if (q.size() == 0) begin
                    check(1'b0, 1, out_data, 8'h00); // R1: unexpected byte
                end else begin
                    e = q.pop_front();
                    check(out_sof == e.sof, 1, {7'd0, out_sof}, {7'd0, e.sof}); // R1
                    if (e.is_b1) begin
                        expb = (prev_par ^ {8{e.inv}}) ^ e.ks;
                        check(out_data == expb, 4, out_data, expb); // R4
                    end else begin
                        check(out_data == e.data, e.req, out_data, e.data);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_sof == 0, 9, {6'd0, out_valid, out_sof}, 8'h00); // R9
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_sof == 0, 9, {6'd0, out_valid, out_sof}, 8'h00); // R9
        send_frame(0, 0, 0, 0, 0, 0); // plain, B1 = 0 for first frame
        send_frame(1, 0, 0, 0, 0, 0); // framing inverted
        send_frame(0, 1, 0, 0, 0, 0); // parity inverted
        send_frame(0, 0, 1, 0, 0, 0); // fault code
        send_frame(1, 1, 1, 1, 0, 0); // transparent overrides
        send_frame(0, 0, 0, 0, 1, 0); // mid-frame control changes ignored
        send_frame(0, 0, 0, 0, 0, 1); // idle gaps
        send_frame(0, 1, 1, 0, 1, 1); // combined
        send_frame(0, 0, 0, 0, 0, 0); // checks parity of combined frame
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        repeat (4) @(negedge clk);
        check(q.size() == 0, 1, 8'(q.size()), 8'h00); // R1: every byte came out
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule